// File: doc/BRIEF.md
# Inter-Core Mailbox Doorbell Unit

This unit lets processor cores signal one another. Every core owns four 32-bit mailboxes, and each bit of a mailbox stands for one independent message. Any core can post messages into any mailbox by writing ones to that mailbox's address in the set window. The owning core reads the live mailbox value from the clear window and removes serviced messages by writing ones to the same address.

Each core has one enable bit. While that bit is on and the core's mailbox 0 holds any message, the core's level interrupt line is high. Every core has its own 32-bit register port into the unit, so several cores can post and clear messages in the same cycle.

Each port runs a three-state machine. In `PS_IDLE` the port is ready and accepts a request. The transition *accept-write* goes from `PS_IDLE` to `PS_WRITE`, and *accept-read* goes from `PS_IDLE` to `PS_READ`. With no request the port takes *stay-idle* and remains in `PS_IDLE`. *write-done* returns from `PS_WRITE` to `PS_IDLE`, and *read-done* returns from `PS_READ` to `PS_IDLE`. A write's side effect lands on the clock edge that ends `PS_WRITE`. Read data is presented during `PS_READ`.

Top module: `mbx_doorbell_top`

## Requirements
- R1: After reset, all mailboxes read zero, all enable bits are off, every interrupt is low and every port's `bus_ready` is high.
- R2: A port accepts a request on a clock edge where `bus_req` and `bus_ready` are both high. `bus_ready` is low for the next cycle. For a read, `bus_rvalid` is high with the data for exactly that one cycle.
- R3: Byte addresses are word-aligned, and bits 1:0 are ignored. With C cores, the set window starts at byte 16·C. Core c's mailbox m is at set-window base + 16·c + 4·m (0x40 + 16c + 4m for four cores). Writing ones sets those mailbox bits, and zeros leave bits unchanged. Reads from the set window return zero.
- R4: The clear window starts at byte 32·C, with core c's mailbox m at clear-window base + 16·c + 4·m (0x80 + 16c + 4m for four cores). Writing ones clears those bits. A read returns the live mailbox value.
- R5: When set and clear writes from different ports hit the same bit in the same cycle, the bit ends up set. Set writes from several ports in one cycle are OR-combined.
- R6: A mailbox changes only when a write hits its address. Writes to unmapped addresses change nothing, and reads from unmapped addresses return zero.
- R7: Core c's enable bit is bit 0 of the word at byte 4·c. It is written as a value and can be read back. Core c's interrupt is high only while this bit is set.
- R8: `core_irq[c]` is registered. It reflects (any bit of core c's mailbox 0) AND (enable), one cycle after those inputs change. It therefore drops the cycle after the last mailbox-0 bit is cleared. Mailboxes 1 to 3 never raise an interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | NUM_CORES | Request strobe, one per core port |
| bus_we | input | NUM_CORES | 1 = write, 0 = read, one per port |
| bus_addr | input | NUM_CORES*ADDR_W | Byte address, packed per port |
| bus_wdata | input | NUM_CORES*DATA_W | Write data, packed per port |
| bus_ready | output | NUM_CORES | Port can accept a request |
| bus_rvalid | output | NUM_CORES | Read data valid |
| bus_rdata | output | NUM_CORES*DATA_W | Read data, packed per port |
| core_irq | output | NUM_CORES | Level interrupt to each core |

## Verification
The bench builds the unit with four cores, 32-bit data and an 8-bit address. With this configuration, every window fits below 0xC0 and addresses from 0xC0 upward are unmapped.

Four independent ports allow two cores to hit the same mailbox bit in one cycle, which exercises the set-over-clear rule and the OR-combining of simultaneous sets. They also allow a core to post into a mailbox it does not own.

The highest mailbox address (0xBC) and unmapped addresses are exercised, as are the exact cycles in which the registered interrupt rises and falls.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBOX_PER_CORE = 4;
    localparam int STRIDE_BYTES  = 16;

    typedef enum logic [1:0] {
        PS_IDLE  = 2'd0,
        PS_WRITE = 2'd1,
        PS_READ  = 2'd2
    } port_state_e;

    typedef enum logic [1:0] {
        WIN_NONE   = 2'd0,
        WIN_ENABLE = 2'd1,
        WIN_SET    = 2'd2,
        WIN_CLEAR  = 2'd3
    } win_e;

endpackage

// File: rtl/mbx_port_fsm.sv
module mbx_port_fsm
    import mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    localparam int NUM_MBOX = NUM_CORES * MBOX_PER_CORE,
    localparam int IDX_W    = $clog2(NUM_MBOX),
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NUM_MBOX*DATA_W-1:0]   mbox_flat,
    input  logic [NUM_CORES-1:0]         en_vec,
    output logic                         ready,
    output logic                         rvalid,
    output logic [DATA_W-1:0]            rdata,
    output logic                         set_vld,
    output logic                         clr_vld,
    output logic                         en_vld,
    output logic [IDX_W-1:0]             tgt,
    output logic [CIDX_W-1:0]            cidx,
    output logic [DATA_W-1:0]            wdata_o
);

    localparam logic [31:0] WIN_BYTES = 32'(NUM_CORES * STRIDE_BYTES);
    localparam logic [31:0] EN_SPAN   = 32'(NUM_CORES * 4);
    localparam logic [31:0] SET_BASE  = WIN_BYTES;
    localparam logic [31:0] CLR_BASE  = 2 * WIN_BYTES;

    port_state_e          state_q, state_d;
    logic                 we_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    win_e                 win;
    logic [31:0]          a32;
    logic [31:0]          off;

    // Address decode of the captured request
    always_comb begin
        a32 = 32'(addr_q) & ~32'h3;
        win = WIN_NONE;
        off = '0;
        if (a32 < EN_SPAN) begin
            win = WIN_ENABLE;
            off = a32;
        end else if (a32 >= SET_BASE && a32 < SET_BASE + WIN_BYTES) begin
            win = WIN_SET;
            off = a32 - SET_BASE;
        end else if (a32 >= CLR_BASE && a32 < CLR_BASE + WIN_BYTES) begin
            win = WIN_CLEAR;
            off = a32 - CLR_BASE;
        end
        tgt  = IDX_W'(off >> 2);
        cidx = CIDX_W'(off >> 2);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_IDLE:  if (req) state_d = we ? PS_WRITE : PS_READ;
            PS_WRITE: state_d = PS_IDLE;
            PS_READ:  state_d = PS_IDLE;
            default:  state_d = PS_IDLE;
        endcase
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (state_q == PS_IDLE && req) begin
            we_q    <= we;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // Outputs per state
    always_comb begin
        ready   = 1'b0;
        rvalid  = 1'b0;
        rdata   = '0;
        set_vld = 1'b0;
        clr_vld = 1'b0;
        en_vld  = 1'b0;
        wdata_o = wdata_q;
        unique case (state_q)
            PS_IDLE:  ready = 1'b1;
            PS_WRITE: begin
                set_vld = we_q && (win == WIN_SET);
                clr_vld = we_q && (win == WIN_CLEAR);
                en_vld  = we_q && (win == WIN_ENABLE);
            end
            PS_READ: begin
                rvalid = 1'b1;
                unique case (win)
                    WIN_ENABLE: rdata = DATA_W'(en_vec[cidx]);
                    WIN_CLEAR:  rdata = mbox_flat[tgt*DATA_W +: DATA_W];
                    default:    rdata = '0;
                endcase
            end
            default: ready = 1'b0;
        endcase
    end

    // R2: an accepted request blocks the port for the next cycle
    a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready);

    // R2: read data is valid for exactly one cycle
    a_r2_rvalid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid);

    // R2: an accepted read produces data in the following cycle
    a_r2_read_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |=> rvalid);

endmodule

// File: rtl/mbx_store.sv
module mbx_store
    import mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    localparam int NUM_MBOX = NUM_CORES * MBOX_PER_CORE,
    localparam int IDX_W    = $clog2(NUM_MBOX),
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          set_vld,
    input  logic [NUM_CORES-1:0]          clr_vld,
    input  logic [NUM_CORES-1:0]          en_vld,
    input  logic [NUM_CORES*IDX_W-1:0]    tgt_flat,
    input  logic [NUM_CORES*CIDX_W-1:0]   cidx_flat,
    input  logic [NUM_CORES*DATA_W-1:0]   wdata_flat,
    output logic [NUM_MBOX*DATA_W-1:0]    mbox_flat,
    output logic [NUM_CORES-1:0]          en_vec
);

    logic [DATA_W-1:0]    mbox_q  [NUM_MBOX];
    logic [DATA_W-1:0]    set_acc [NUM_MBOX];
    logic [DATA_W-1:0]    clr_acc [NUM_MBOX];
    logic [NUM_CORES-1:0] en_q, en_d;

    // Gather set and clear masks from every port
    always_comb begin
        for (int i = 0; i < NUM_MBOX; i++) begin
            set_acc[i] = '0;
            clr_acc[i] = '0;
            for (int p = 0; p < NUM_CORES; p++) begin
                if (tgt_flat[p*IDX_W +: IDX_W] == IDX_W'(i)) begin
                    if (set_vld[p]) set_acc[i] = set_acc[i] | wdata_flat[p*DATA_W +: DATA_W];
                    if (clr_vld[p]) clr_acc[i] = clr_acc[i] | wdata_flat[p*DATA_W +: DATA_W];
                end
            end
        end
    end

    // Mailbox registers: set applied after clear, so set wins
    for (genvar g = 0; g < NUM_MBOX; g++) begin : g_mbox
        always_ff @(posedge clk) begin
            if (!rst_n) mbox_q[g] <= '0;
            else        mbox_q[g] <= (mbox_q[g] & ~clr_acc[g]) | set_acc[g];
        end
        assign mbox_flat[g*DATA_W +: DATA_W] = mbox_q[g];

        // R5: every bit posted in a cycle is present afterwards
        a_r5_set_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (|set_acc[g]) |=> ((mbox_q[g] & $past(set_acc[g])) == $past(set_acc[g])));

        // R4: cleared bits not re-posted are gone afterwards
        a_r4_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
            (|clr_acc[g]) |=> ((mbox_q[g] & $past(clr_acc[g] & ~set_acc[g])) == '0));

        // R6: untouched mailbox holds its value
        a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!(|set_acc[g]) && !(|clr_acc[g])) |=> $stable(mbox_q[g]));
    end

    // Enable bits: lowest-numbered port wins on a collision
    always_comb begin
        en_d = en_q;
        for (int p = NUM_CORES - 1; p >= 0; p--) begin
            if (en_vld[p]) en_d[cidx_flat[p*CIDX_W +: CIDX_W]] = wdata_flat[p*DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= '0;
        else        en_q <= en_d;
    end

    assign en_vec = en_q;

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CORES*DATA_W-1:0] mb0_flat,
    input  logic [NUM_CORES-1:0]        en_vec,
    output logic [NUM_CORES-1:0]        irq
);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        logic [DATA_W-1:0] mb0;
        assign mb0 = mb0_flat[c*DATA_W +: DATA_W];

        always_ff @(posedge clk) begin
            if (!rst_n) irq[c] <= 1'b0;
            else        irq[c] <= (|mb0) & en_vec[c];
        end

        // R7: a disabled core sees no interrupt in the next cycle
        a_r7_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
            !en_vec[c] |=> !irq[c]);

        // R8: steady mailbox 0 and enable give a steady interrupt
        a_r8_steady: assert property (@(posedge clk) disable iff (!rst_n)
            ($stable(mb0) && $stable(en_vec[c])) |=> $stable(irq[c]));
    end

endmodule

// File: rtl/mbx_doorbell_top.sv
module mbx_doorbell_top
    import mbx_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_CORES-1:0]          bus_req,
    input  logic [NUM_CORES-1:0]          bus_we,
    input  logic [NUM_CORES*ADDR_W-1:0]   bus_addr,
    input  logic [NUM_CORES*DATA_W-1:0]   bus_wdata,
    output logic [NUM_CORES-1:0]          bus_ready,
    output logic [NUM_CORES-1:0]          bus_rvalid,
    output logic [NUM_CORES*DATA_W-1:0]   bus_rdata,
    output logic [NUM_CORES-1:0]          core_irq
);

    localparam int NUM_MBOX = NUM_CORES * MBOX_PER_CORE;
    localparam int IDX_W    = $clog2(NUM_MBOX);
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1;

    logic [NUM_CORES-1:0]        set_vld, clr_vld, en_vld;
    logic [NUM_CORES*IDX_W-1:0]  tgt_flat;
    logic [NUM_CORES*CIDX_W-1:0] cidx_flat;
    logic [NUM_CORES*DATA_W-1:0] wdata_flat;
    logic [NUM_MBOX*DATA_W-1:0]  mbox_flat;
    logic [NUM_CORES*DATA_W-1:0] mb0_flat;
    logic [NUM_CORES-1:0]        en_vec;

    for (genvar p = 0; p < NUM_CORES; p++) begin : g_port
        mbx_port_fsm #(
            .NUM_CORES (NUM_CORES),
            .DATA_W    (DATA_W),
            .ADDR_W    (ADDR_W)
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (bus_req[p]),
            .we        (bus_we[p]),
            .addr      (bus_addr[p*ADDR_W +: ADDR_W]),
            .wdata     (bus_wdata[p*DATA_W +: DATA_W]),
            .mbox_flat (mbox_flat),
            .en_vec    (en_vec),
            .ready     (bus_ready[p]),
            .rvalid    (bus_rvalid[p]),
            .rdata     (bus_rdata[p*DATA_W +: DATA_W]),
            .set_vld   (set_vld[p]),
            .clr_vld   (clr_vld[p]),
            .en_vld    (en_vld[p]),
            .tgt       (tgt_flat[p*IDX_W +: IDX_W]),
            .cidx      (cidx_flat[p*CIDX_W +: CIDX_W]),
            .wdata_o   (wdata_flat[p*DATA_W +: DATA_W])
        );

        assign mb0_flat[p*DATA_W +: DATA_W] =
            mbox_flat[(p*MBOX_PER_CORE)*DATA_W +: DATA_W];
    end

    mbx_store #(
        .NUM_CORES (NUM_CORES),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vld    (set_vld),
        .clr_vld    (clr_vld),
        .en_vld     (en_vld),
        .tgt_flat   (tgt_flat),
        .cidx_flat  (cidx_flat),
        .wdata_flat (wdata_flat),
        .mbox_flat  (mbox_flat),
        .en_vec     (en_vec)
    );

    mbx_irq #(
        .NUM_CORES (NUM_CORES),
        .DATA_W    (DATA_W)
    ) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .mb0_flat (mb0_flat),
        .en_vec   (en_vec),
        .irq      (core_irq)
    );

endmodule

// File: tb/mbx_doorbell_top_bench.sv
module mbx_doorbell_top_bench;

    localparam int NC = 4;
    localparam int DW = 32;
    localparam int AW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NC-1:0]     bus_req = '0;
    logic [NC-1:0]     bus_we = '0;
    logic [NC*AW-1:0]  bus_addr = '0;
    logic [NC*DW-1:0]  bus_wdata = '0;
    logic [NC-1:0]     bus_ready;
    logic [NC-1:0]     bus_rvalid;
    logic [NC*DW-1:0]  bus_rdata;
    logic [NC-1:0]     core_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    mbx_doorbell_top #(.NUM_CORES(NC), .DATA_W(DW), .ADDR_W(AW)) u_mbx_doorbell_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata), .core_irq(core_irq)
    );

    typedef struct packed {
        logic [1:0]  port;
        logic        we;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'd1, 1'b1, 8'h40, 32'h0000_0005, 32'h0, 4'd3},  // R3 post to core0 mb0 from port 1
        '{2'd0, 1'b0, 8'h80, 32'h0,         32'h0000_0005, 4'd4},  // R4 live read
        '{2'd2, 1'b1, 8'h40, 32'h0000_0100, 32'h0, 4'd3},  // R3 second post ORs in
        '{2'd0, 1'b0, 8'h80, 32'h0,         32'h0000_0105, 4'd3},
        '{2'd0, 1'b1, 8'h80, 32'h0000_0004, 32'h0, 4'd4},  // R4 clear bit 2
        '{2'd0, 1'b0, 8'h80, 32'h0,         32'h0000_0101, 4'd4},
        '{2'd3, 1'b1, 8'h7C, 32'h8000_0000, 32'h0, 4'd3},  // R3 last mailbox
        '{2'd3, 1'b0, 8'hBC, 32'h0,         32'h8000_0000, 4'd4},
        '{2'd0, 1'b0, 8'h7C, 32'h0,         32'h0, 4'd3},  // R3 set window reads zero
        '{2'd1, 1'b1, 8'h04, 32'h0000_0001, 32'h0, 4'd7},  // R7 enable core1
        '{2'd2, 1'b0, 8'h04, 32'h0,         32'h0000_0001, 4'd7},
        '{2'd1, 1'b1, 8'h98, 32'hFFFF_FFFF, 32'h0, 4'd4},  // R4 clear empty box
        '{2'd1, 1'b0, 8'h98, 32'h0,         32'h0, 4'd4},
        '{2'd0, 1'b1, 8'hF0, 32'hFFFF_FFFF, 32'h0, 4'd6},  // R6 unmapped write
        '{2'd0, 1'b0, 8'hF0, 32'h0,         32'h0, 4'd6},  // R6 unmapped read
        '{2'd0, 1'b0, 8'hBC, 32'h0,         32'h8000_0000, 4'd6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int p, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req[p] = 1'b1; bus_we[p] = 1'b1;
        bus_addr[p*AW +: AW] = a; bus_wdata[p*DW +: DW] = d;
        @(negedge clk);
        bus_req[p] = 1'b0; bus_we[p] = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input int p, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_req[p] = 1'b1; bus_we[p] = 1'b0; bus_addr[p*AW +: AW] = a;
        @(negedge clk);
        bus_req[p] = 1'b0;
        check("R2 rvalid during read", 32'(bus_rvalid[p]), 32'h1);
        d = bus_rdata[p*DW +: DW];
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog all requirements actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready after reset", 32'(bus_ready), 32'hF);
        check("R1 irq after reset", 32'(core_irq), 32'h0);
        do_read(0, 8'h80, rd); check("R1 core0 mb0 zero", rd, 32'h0);
        do_read(1, 8'hBC, rd); check("R1 core3 mb3 zero", rd, 32'h0);
        do_read(2, 8'h00, rd); check("R1 enable off", rd, 32'h0);

        // R2 ready drops for the cycle after acceptance
        @(negedge clk);
        bus_req[3] = 1'b1; bus_we[3] = 1'b0; bus_addr[3*AW +: AW] = 8'h00;
        @(negedge clk);
        bus_req[3] = 1'b0;
        check("R2 ready low while busy", 32'(bus_ready[3]), 32'h0);
        @(negedge clk);
        check("R2 rvalid single cycle", 32'(bus_rvalid[3]), 32'h0);
        check("R2 ready back", 32'(bus_ready[3]), 32'h1);

        // Vector table
        for (int k = 0; k < 16; k++) begin
            if (VECS[k].we) begin
                do_write(int'(VECS[k].port), VECS[k].addr, VECS[k].data);
            end else begin
                do_read(int'(VECS[k].port), VECS[k].addr, rd);
                check($sformatf("R%0d vector %0d", VECS[k].rq, k), rd, VECS[k].exp);
            end
        end

        // R5 set and clear on the same bit in one cycle: set wins
        do_write(2, 8'h60, 32'h0000_00F0);
        @(negedge clk);
        bus_req[0] = 1'b1; bus_we[0] = 1'b1; bus_addr[0 +: AW] = 8'h60; bus_wdata[0 +: DW] = 32'h10;
        bus_req[1] = 1'b1; bus_we[1] = 1'b1; bus_addr[AW +: AW] = 8'hA0; bus_wdata[DW +: DW] = 32'h30;
        @(negedge clk);
        bus_req = '0; bus_we = '0;
        @(negedge clk);
        do_read(2, 8'hA0, rd); check("R5 set beats clear", rd, 32'h0000_00D0);

        // R5 two sets in one cycle combine
        @(negedge clk);
        bus_req[0] = 1'b1; bus_we[0] = 1'b1; bus_addr[0 +: AW] = 8'h60; bus_wdata[0 +: DW] = 32'h1;
        bus_req[3] = 1'b1; bus_we[3] = 1'b1; bus_addr[3*AW +: AW] = 8'h60; bus_wdata[3*DW +: DW] = 32'h2;
        @(negedge clk);
        bus_req = '0; bus_we = '0;
        @(negedge clk);
        do_read(1, 8'hA0, rd); check("R5 sets combine", rd, 32'h0000_00D3);

        // R7 core0 holds messages but is disabled; core1 enabled but empty
        check("R7 no irq while disabled", 32'(core_irq), 32'h0);

        // R8 mailbox 1 never raises the interrupt
        do_write(1, 8'h54, 32'h1);
        @(negedge clk);
        check("R8 mailbox1 no irq", 32'(core_irq[1]), 32'h0);

        // R8 registered rise
        do_write(2, 8'h50, 32'h4);
        check("R8 irq not yet", 32'(core_irq[1]), 32'h0);
        @(negedge clk);
        check("R8 irq rises", 32'(core_irq[1]), 32'h1);

        // R7 enable gates the interrupt
        do_write(0, 8'h00, 32'h1);
        @(negedge clk);
        check("R7 irq on enable", 32'(core_irq[0]), 32'h1);
        do_write(0, 8'h00, 32'h0);
        @(negedge clk);
        check("R7 irq off when disabled", 32'(core_irq[0]), 32'h0);
        do_write(0, 8'h00, 32'h1);
        @(negedge clk);

        // R8 falls only after the last bit is cleared
        do_write(0, 8'h80, 32'h1);
        @(negedge clk);
        check("R8 irq held with bit left", 32'(core_irq[0]), 32'h1);
        do_write(0, 8'h80, 32'h100);
        check("R8 irq still high at clear", 32'(core_irq[0]), 32'h1);
        @(negedge clk);
        check("R8 irq drops next cycle", 32'(core_irq[0]), 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule